// File: doc/BRIEF.md
# A/D Conversion Sequencer

This block is the digital control for a four-input successive-approximation A/D converter. Software-side logic first enables the conversion clock, marks which analog inputs are in use with a one-bit-per-input mask, and picks one of four channels with a 2-bit code. A single-cycle start strobe then begins a conversion. The block routes the chosen channel through the external multiplexer and holds the sample/hold switch closed for a fixed window. It then steps a 10-bit trial value, most significant bit first, into the external DAC and keeps or drops each bit according to the external comparator.

All timing counts conversion-clock ticks. A tick is a one-cycle pulse from an outside prescaler, and it only counts while the tick enable is high. From the first sampling tick to the loading of the result, a conversion takes 21 ticks. Of these, 8 are sampling, 10 are bit trials and 3 are settling. The result register and a one-cycle completion pulse update on the same clock edge.

Suppose the selected channel's mask bit was clear when the conversion started. The conversion still runs its full course and pulses completion. The result register keeps its old contents and an invalid flag is raised, so no bad data is stored.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted and just after its release: result 0, result_invalid 0, busy 0, done 0, sample_hold 0.
- R2: A start accepted from idle latches chan_sel. mux_sel then equals that code for the whole conversion. Code 0 is the lowest analog input, and mask bit i belongs to channel code i.
- R3: Sampling begins at the first qualified tick after the start strobe is accepted. That tick may come in the same conversion-clock period as the start or in the next one, so the delay is 0 to 1 tick periods.
- R4: sample_hold is high for exactly 8 qualified ticks per conversion.
- R5: Exactly 21 qualified ticks are consumed from the first sampling tick up to and including the tick that loads the result. done is high for one clock cycle, in the cycle where the new result first appears.
- R6: The result is resolved MSB first, and the first trial value shown on dac_code is 10'h200. With a comparator that answers "trial <= input", the stored result equals the input code.
- R7: If term_en[chan_sel] was 0 when the start was accepted, then at completion result_invalid is 1 and result keeps its previous value. A valid conversion clears result_invalid.
- R8: A start strobe while busy is ignored: mux_sel does not change, and no additional conversion or completion follows.
- R9: busy is 1 from the cycle after an accepted start until the completion cycle, in which it reads 0.
- R10: Tick pulses while tick_en is 0 do not advance the sequence.
- R11: result changes only in a cycle where done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Conversion clock output enable |
| tick | input | 1 | One-cycle conversion-clock tick from the prescaler |
| term_en | input | 4 | Analog input enable mask, bit i for channel code i |
| chan_sel | input | 2 | Channel code for the next conversion |
| start | input | 1 | Run strobe, one cycle |
| cmp_in | input | 1 | Comparator: 1 when the DAC trial is at or below the input |
| mux_sel | output | 2 | Analog multiplexer select |
| sample_hold | output | 1 | Sample switch control, high while sampling |
| dac_code | output | 10 | Trial value for the DAC |
| result | output | 10 | Conversion data register |
| result_invalid | output | 1 | Last completion had a disabled channel |
| done | output | 1 | Completion pulse |
| busy | output | 1 | Conversion in progress |

## Verification
The input codes 0, 1023, 512, 511, 0x2AA and 0x155 are converted. The two extremes show whether every bit is kept or dropped. The 512/511 pair tells an MSB decision apart from the decisions of all the lower bits. The alternating patterns expose a bit whose index or order is wrong. Each conversion runs on a different channel and mask, so the latched select can be told apart from the live one, and a cleared mask bit checks that the register holds its old value. Further runs cover a start during busy, tick pulses with tick_en low, and the cycle-level tick counts for latency, sampling and the total.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ARM  = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int RES_W        = 10,
  parameter int CH_W         = 2,
  parameter int SAMPLE_TICKS = 8,
  parameter int TOTAL_TICKS  = 21,
  localparam int CNT_W       = $clog2(TOTAL_TICKS + 1),
  localparam int IDX_W       = (RES_W > 1) ? $clog2(RES_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tk,
  input  logic             start,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic             chan_ok,
  output logic [CH_W-1:0]  chan_q,
  output logic             chan_ok_q,
  output logic             busy,
  output logic             sample_hold,
  output logic             trial_act,
  output logic [IDX_W-1:0] bit_idx,
  output logic             clear_acc,
  output logic             step,
  output logic             load
);

  localparam logic [CNT_W-1:0] LAST_CNT   = CNT_W'(TOTAL_TICKS - 1);
  localparam logic [CNT_W-1:0] SAMP_END   = CNT_W'(SAMPLE_TICKS);
  localparam logic [CNT_W-1:0] TRIAL_END  = CNT_W'(SAMPLE_TICKS + RES_W);
  localparam logic [CNT_W-1:0] TOP_BIT    = CNT_W'(RES_W - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CH_W-1:0]  chan_d;
  logic             ok_d;
  logic [CNT_W-1:0] trial_n;
  logic [CNT_W-1:0] idx_full;
  logic             in_run;

  // next-state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    chan_d  = chan_q;
    ok_d    = chan_ok_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_ARM;
          chan_d  = chan_sel;
          ok_d    = chan_ok;
        end
      end
      SEQ_ARM: begin
        if (tk) begin
          state_d = SEQ_RUN;
          cnt_d   = '0;
        end
      end
      SEQ_RUN: begin
        if (tk) begin
          if (cnt_q == LAST_CNT) begin
            state_d = SEQ_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      cnt_q     <= '0;
      chan_q    <= '0;
      chan_ok_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      chan_q    <= chan_d;
      chan_ok_q <= ok_d;
    end
  end

  // decoded phase outputs
  always_comb begin
    in_run      = (state_q == SEQ_RUN);
    busy        = (state_q != SEQ_IDLE);
    sample_hold = in_run && (cnt_q < SAMP_END);
    trial_act   = in_run && (cnt_q >= SAMP_END) && (cnt_q < TRIAL_END);
    trial_n     = cnt_q - SAMP_END;
    idx_full    = TOP_BIT - trial_n;
    bit_idx     = idx_full[IDX_W-1:0];
    clear_acc   = (state_q == SEQ_ARM) && tk;
    step        = trial_act && tk;
    load        = in_run && tk && (cnt_q == LAST_CNT);
  end

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int RES_W  = 10,
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_acc,
  input  logic             step,
  input  logic             trial_act,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             cmp_in,
  output logic [RES_W-1:0] acc,
  output logic [RES_W-1:0] dac_code
);

  logic [RES_W-1:0] acc_d;

  for (genvar gi = 0; gi < RES_W; gi++) begin : g_bit
    logic hit;
    always_comb begin
      hit = (bit_idx == IDX_W'(gi));
      if (clear_acc)
        acc_d[gi] = 1'b0;
      else if (step && hit)
        acc_d[gi] = cmp_in;
      else
        acc_d[gi] = acc[gi];
      dac_code[gi] = acc[gi] | (trial_act && hit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_d;
  end

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             chan_ok,
  input  logic [RES_W-1:0] acc,
  output logic [RES_W-1:0] result,
  output logic             result_invalid,
  output logic             done
);

  logic [RES_W-1:0] data_d;
  logic             inv_d;
  logic             data_en;

  always_comb begin
    data_en = load && chan_ok;
    data_d  = data_en ? acc : result;
    inv_d   = load ? !chan_ok : result_invalid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result         <= '0;
      result_invalid <= 1'b0;
      done           <= 1'b0;
    end else begin
      result         <= data_d;
      result_invalid <= inv_d;
      done           <= load;
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES_W        = 10,
  parameter int N_CH         = 4,
  parameter int SAMPLE_TICKS = 8,
  parameter int TOTAL_TICKS  = 21,
  localparam int CH_W        = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int IDX_W       = (RES_W > 1) ? $clog2(RES_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             tick,
  input  logic [N_CH-1:0]  term_en,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic             start,
  input  logic             cmp_in,
  output logic [CH_W-1:0]  mux_sel,
  output logic             sample_hold,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             result_invalid,
  output logic             done,
  output logic             busy
);

  logic             tk;
  logic             chan_ok;
  logic             chan_ok_q;
  logic             trial_act;
  logic [IDX_W-1:0] bit_idx;
  logic             clear_acc;
  logic             step;
  logic             load;
  logic [RES_W-1:0] acc;

  always_comb begin
    tk      = tick && tick_en;
    chan_ok = term_en[chan_sel];
  end

  adc_seq_timer #(
    .RES_W       (RES_W),
    .CH_W        (CH_W),
    .SAMPLE_TICKS(SAMPLE_TICKS),
    .TOTAL_TICKS (TOTAL_TICKS)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tk         (tk),
    .start      (start),
    .chan_sel   (chan_sel),
    .chan_ok    (chan_ok),
    .chan_q     (mux_sel),
    .chan_ok_q  (chan_ok_q),
    .busy       (busy),
    .sample_hold(sample_hold),
    .trial_act  (trial_act),
    .bit_idx    (bit_idx),
    .clear_acc  (clear_acc),
    .step       (step),
    .load       (load)
  );

  adc_sar_reg #(.RES_W(RES_W)) u_sar (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_acc(clear_acc),
    .step     (step),
    .trial_act(trial_act),
    .bit_idx  (bit_idx),
    .cmp_in   (cmp_in),
    .acc      (acc),
    .dac_code (dac_code)
  );

  adc_result_reg #(.RES_W(RES_W)) u_result (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (load),
    .chan_ok       (chan_ok_q),
    .acc           (acc),
    .result        (result),
    .result_invalid(result_invalid),
    .done          (done)
  );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int RES_W        = 10,
  parameter int CH_W         = 2,
  parameter int SAMPLE_TICKS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             tick_en,
  input logic             busy,
  input logic             done,
  input logic             sample_hold,
  input logic [CH_W-1:0]  mux_sel,
  input logic [RES_W-1:0] dac_code,
  input logic [RES_W-1:0] result,
  input logic             result_invalid
);

  int unsigned sh_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         sh_cnt <= 0;
    else if (sample_hold && tick && tick_en) sh_cnt <= sh_cnt + 1;
    else if (!sample_hold)              sh_cnt <= 0;
  end

  // R5: completion is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: busy only drops in the completion cycle
  a_r9_busy_clears_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8: channel select frozen while a conversion continues
  a_r8_mux_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(mux_sel)));

  // R11: data register only moves with completion
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R7: invalid completion leaves data untouched
  a_r7_invalid_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result_invalid) |-> $stable(result));

  // R4: sampling window spans the configured number of ticks
  a_r4_sample_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_hold) |-> (sh_cnt == SAMPLE_TICKS));

  // R6: first trial after sampling is the top bit alone
  a_r6_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_hold) |-> (dac_code == (RES_W)'(1) << (RES_W - 1)));

  // R10: without the tick enable the sampling switch does not move
  a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(sample_hold));

  // sampling only inside a busy period
  a_r9_sample_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sample_hold |-> busy);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
  .RES_W       (RES_W),
  .CH_W        (CH_W),
  .SAMPLE_TICKS(SAMPLE_TICKS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick          (tick),
  .tick_en       (tick_en),
  .busy          (busy),
  .done          (done),
  .sample_hold   (sample_hold),
  .mux_sel       (mux_sel),
  .dac_code      (dac_code),
  .result        (result),
  .result_invalid(result_invalid)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;

  localparam int TICK_DIV = 3;

  typedef struct {
    logic [9:0] res;
    logic       inv;
    logic [1:0] ch;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       tick = 1'b0;
  logic [3:0] term_en = 4'h0;
  logic [1:0] chan_sel = 2'd0;
  logic       start = 1'b0;
  logic       cmp_in;
  logic [1:0] mux_sel;
  logic       sample_hold;
  logic [9:0] dac_code;
  logic [9:0] result;
  logic       result_invalid;
  logic       done;
  logic       busy;

  logic [9:0] vin = 10'd0;
  int         div = 0;
  int         errors = 0;
  int         checks = 0;
  int         done_cnt = 0;
  logic [9:0] last_res = 10'd0;
  exp_t       sb[$];

  always #10 clk = ~clk;

  // behavioural comparator
  always_comb cmp_in = (dac_code <= vin);

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tick(tick),
    .term_en(term_en), .chan_sel(chan_sel), .start(start), .cmp_in(cmp_in),
    .mux_sel(mux_sel), .sample_hold(sample_hold), .dac_code(dac_code),
    .result(result), .result_invalid(result_invalid), .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // tick generator, driven away from the active edge
  always @(posedge clk) begin
    #2;
    div  = (div == TICK_DIV - 1) ? 0 : div + 1;
    tick = (div == 0);
  end

  // monitor / scoreboard
  bit   armed = 0, in_conv = 0, prev_sh = 0, done_prev = 0;
  int   lat = 0, samp = 0, conv = 0;
  exp_t cur;
  always @(negedge clk) begin
    automatic bit tk = tick && tick_en;
    if (rst_n) begin
      if (done_prev) chk(!done, "R5 done width", done, 0);
      if (done) begin
        done_cnt++;
        chk(conv == 21, "R5 tick total", conv, 21);
        chk(!busy, "R9 busy clear", busy, 0);
        if (sb.size() == 0) chk(0, "R8 unexpected completion", 1, 0);
        else begin
          cur = sb.pop_front();
          chk(result_invalid == cur.inv, "R7 invalid flag", result_invalid, cur.inv);
          chk(result == cur.res, "R6/R7 result", result, cur.res);
        end
        in_conv = 0;
      end else if (in_conv) begin
        chk(busy, "R9 busy during", busy, 1);
        if (prev_sh && !sample_hold) begin
          chk(samp == 8, "R4 sample ticks", samp, 8);
          chk(dac_code == 10'h200, "R6 first trial", dac_code, 10'h200);
        end
        if (tk) conv++;
        if (sample_hold && tk) samp++;
      end else if (armed) begin
        if (sample_hold) begin
          chk(lat == 1, "R3 start latency", lat, 1);
          if (sb.size() > 0)
            chk(mux_sel == sb[0].ch, "R2 mux select", mux_sel, sb[0].ch);
          armed = 0; in_conv = 1;
          conv = tk ? 1 : 0;
          samp = tk ? 1 : 0;
        end else if (tk) lat++;
      end
      if (start && !busy && !armed && !in_conv) begin
        armed = 1; lat = 0;
      end
    end
    prev_sh   = sample_hold;
    done_prev = done;
  end

  task automatic convert(input logic [9:0] v, input logic [1:0] ch,
                         input logic [3:0] mask, input bit extra);
    exp_t e;
    int target = done_cnt + 1;
    e.ch  = ch;
    e.inv = !mask[ch];
    e.res = e.inv ? last_res : v;
    if (!e.inv) last_res = v;
    sb.push_back(e);
    @(posedge clk); #3;
    vin = v; chan_sel = ch; term_en = mask; start = 1'b1;
    @(posedge clk); #3;
    start = 1'b0;
    if (extra) begin
      wait (sample_hold);
      @(posedge clk); #3;
      chan_sel = ~ch; start = 1'b1;
      @(posedge clk); #3;
      start = 1'b0;
      @(negedge clk);
      chk(mux_sel == ch, "R8 mux kept", mux_sel, ch);
      chk(busy, "R8 still busy", busy, 1);
      chan_sel = ch;
    end
    wait (done_cnt == target);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(result == 0, "R1 result", result, 0);
    chk(!result_invalid && !busy && !done && !sample_hold, "R1 flags",
        {result_invalid, busy, done, sample_hold}, 0);
    @(posedge clk); #3; rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && result == 0, "R1 after release", busy, 0);

    convert(10'd0,    2'd0, 4'b0001, 0);
    convert(10'd1023, 2'd1, 4'b0010, 0);
    convert(10'd512,  2'd2, 4'b1100, 0);
    convert(10'd511,  2'd3, 4'b1111, 0);
    convert(10'h2AA,  2'd1, 4'b0011, 1);
    // disabled channel: data kept, flag set
    convert(10'h155,  2'd2, 4'b1011, 0);
    @(negedge clk);
    chk(result == 10'h2AA, "R7 data kept", result, 10'h2AA);
    convert(10'h155,  2'd0, 4'b0001, 0);
    chk(!result_invalid, "R7 flag cleared", result_invalid, 0);

    // R11: result holds between conversions
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(result == 10'h155, "R11 hold", result, 10'h155);

    // R10: ticks without enable do nothing
    @(posedge clk); #3; tick_en = 1'b0;
    fork
      convert(10'd300, 2'd3, 4'b1000, 0);
      begin
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(busy && !sample_hold, "R10 stalled", sample_hold, 0);
        chk(result == 10'h155, "R11 hold while stalled", result, 10'h155);
        #3 tick_en = 1'b1;
      end
    join
    chk(done_cnt == 8, "R8 completion count", done_cnt, 8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule